// File: doc/BRIEF.md
# Single-Bus Register Swap Sequencer

This block holds four general-purpose registers and one scratch register, all fed from one shared bus. A source multiplexer puts exactly one value on the bus each cycle, chosen by a 3-bit select code. Any number of registers may load that value at the same clock edge, each under its own load enable. The multiplexer has six sources: the four general registers, the scratch register, and an external data input. The external input is the only way to bring new values into the bank.

A small controller accepts commands over a valid/busy/done handshake. There are four commands: a single copy, a pair of copies, an exchange of two registers, and a load from the external input. Because the bus carries one transfer per cycle, the controller turns each command into an ordered run of bus cycles. In each cycle it drives the select code and the load enables. An exchange routes one value through the scratch register, so it takes three cycles.

Top module: `regswap_bus_top`

## Requirements
- R1: A storage register (general registers 0-3, scratch register 4) takes the bus value at a clock edge where its `bus_load` bit is 1. Otherwise it keeps its value.
- R2: `bus_sel` names the single source on the bus: codes 0-3 pick the general register of that index, 4 picks the scratch register, and 5 picks `ext_data`. `bus_data` equals the selected source.
- R3: Opcode 0 (copy) spends one bus cycle with `bus_sel` = `cmd_src_a` and loads `cmd_dst_a`. This still holds when source and destination are the same register.
- R4: Opcode 1 (pair) spends two bus cycles. The first copies `cmd_src_a` into `cmd_dst_a`. The second copies `cmd_src_b` into `cmd_dst_b`, so the second copy sees the result of the first.
- R5: Opcode 2 (exchange of `cmd_dst_a` = i and `cmd_src_a` = j, with i ≠ j) spends three bus cycles in this order: scratch ← Ri (select i, load bit 4), then Ri ← Rj (select j), then Rj ← scratch (select 4).
- R6: An exchange with i = j spends one bus cycle with no load bit set. It leaves all five registers unchanged.
- R7: Opcode 3 (load) spends one bus cycle with select 5. It writes the value on `ext_data` during that cycle into `cmd_dst_a`.
- R8: A command is taken at an edge where `cmd_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly the command's bus cycles, starting the next cycle. `done` is 1 for the single cycle that follows the last bus cycle. `cmd_valid` while `busy` is 1 has no effect. No load bit is set while `busy` is 0.
- R9: Reset clears all five registers and leaves the controller idle, with `busy`, `done` and `bus_load` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 0 copy, 1 pair, 2 exchange, 3 load |
| cmd_dst_a | input | 2 | First destination, or exchange operand i |
| cmd_src_a | input | 2 | First source, or exchange operand j |
| cmd_dst_b | input | 2 | Second destination (pair only) |
| cmd_src_b | input | 2 | Second source (pair only) |
| ext_data | input | DATA_W | External value for the load command |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| bus_sel | output | 3 | Current source select code |
| bus_load | output | 5 | Current load enables, bit 4 = scratch |
| bus_data | output | DATA_W | Value on the shared bus |
| gp_regs | output | 4*DATA_W | General registers, register k at bits k*DATA_W upward |
| tmp_reg | output | DATA_W | Scratch register |

## Verification
The hardest cases to reach from the ports are exchanges and pairs that start from a bank holding four distinct values. Only then does a wrong order or a wrong operand show up as a wrong result. Before every sweep point the bench therefore loads fresh, position-dependent values through the load command. It then walks every operand combination of copy, exchange and pair. A rejected command is checked by raising `cmd_valid` in the middle of an exchange.

// File: rtl/swapbus_pkg.sv
package swapbus_pkg;
  localparam int unsigned NUM_GP    = 4;
  localparam int unsigned NUM_STORE = NUM_GP + 1;
  localparam int unsigned NUM_SRC   = NUM_STORE + 1;
  localparam int unsigned SEL_W     = 3;
  localparam int unsigned IDX_W     = 2;
  localparam int unsigned TMP_IDX   = NUM_GP;
  localparam int unsigned EXT_IDX   = NUM_STORE;

  typedef enum logic [1:0] {
    OP_COPY = 2'd0,
    OP_PAIR = 2'd1,
    OP_XCHG = 2'd2,
    OP_LOAD = 2'd3
  } op_e;
endpackage

// File: rtl/swapbus_store.sv
module swapbus_store #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_REG = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REG-1:0]              ld,
  input  logic [DATA_W-1:0]               bus_data,
  output logic [NUM_REG-1:0][DATA_W-1:0]  q
);
  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[g] <= '0;
      end else if (ld[g]) begin
        q[g] <= bus_data;
      end
    end
  end
endmodule

// File: rtl/swapbus_srcmux.sv
module swapbus_srcmux #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NUM_IN = 6,
  parameter int unsigned SEL_W  = 3
) (
  input  logic [NUM_IN-1:0][DATA_W-1:0] src,
  input  logic [SEL_W-1:0]              sel,
  output logic [DATA_W-1:0]             bus
);
  logic [NUM_IN-1:0] hit;

  for (genvar s = 0; s < NUM_IN; s++) begin : g_dec
    assign hit[s] = (sel == SEL_W'(s));
  end

  always_comb begin
    bus = '0;
    for (int s = 0; s < NUM_IN; s++) begin
      bus = bus | (src[s] & {DATA_W{hit[s]}});
    end
  end
endmodule

// File: rtl/swapbus_seq.sv
module swapbus_seq
  import swapbus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [IDX_W-1:0]     cmd_dst_a,
  input  logic [IDX_W-1:0]     cmd_src_a,
  input  logic [IDX_W-1:0]     cmd_dst_b,
  input  logic [IDX_W-1:0]     cmd_src_b,
  output logic                 busy,
  output logic                 done,
  output logic [SEL_W-1:0]     sel,
  output logic [NUM_STORE-1:0] ld
);
  logic             run_q, run_d;
  logic [1:0]       step_q, step_d;
  logic             done_q, done_d;
  op_e              op_q;
  logic [IDX_W-1:0] da_q, sa_q, db_q, sb_q;
  logic             accept;
  logic [1:0]       last_step;

  function automatic logic [NUM_STORE-1:0] pick(input logic [SEL_W-1:0] idx);
    return NUM_STORE'(1) << idx;
  endfunction

  assign accept = cmd_valid && !run_q;

  always_comb begin
    case (op_q)
      OP_PAIR: last_step = 2'd1;
      OP_XCHG: last_step = (da_q == sa_q) ? 2'd0 : 2'd2;
      default: last_step = 2'd0;
    endcase
  end

  always_comb begin
    run_d  = run_q;
    step_d = step_q;
    done_d = 1'b0;
    if (run_q) begin
      if (step_q == last_step) begin
        run_d  = 1'b0;
        step_d = 2'd0;
        done_d = 1'b1;
      end else begin
        step_d = step_q + 2'd1;
      end
    end else if (accept) begin
      run_d  = 1'b1;
      step_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= 2'd0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_COPY;
      da_q <= '0;
      sa_q <= '0;
      db_q <= '0;
      sb_q <= '0;
    end else if (accept) begin
      op_q <= op_e'(cmd_op);
      da_q <= cmd_dst_a;
      sa_q <= cmd_src_a;
      db_q <= cmd_dst_b;
      sb_q <= cmd_src_b;
    end
  end

  always_comb begin
    sel = '0;
    ld  = '0;
    if (run_q) begin
      case (op_q)
        OP_COPY: begin
          sel = SEL_W'(sa_q);
          ld  = pick(SEL_W'(da_q));
        end
        OP_PAIR: begin
          if (step_q == 2'd0) begin
            sel = SEL_W'(sa_q);
            ld  = pick(SEL_W'(da_q));
          end else begin
            sel = SEL_W'(sb_q);
            ld  = pick(SEL_W'(db_q));
          end
        end
        OP_XCHG: begin
          if (da_q == sa_q) begin
            sel = SEL_W'(da_q);
          end else begin
            case (step_q)
              2'd0: begin
                sel = SEL_W'(da_q);
                ld  = pick(SEL_W'(TMP_IDX));
              end
              2'd1: begin
                sel = SEL_W'(sa_q);
                ld  = pick(SEL_W'(da_q));
              end
              default: begin
                sel = SEL_W'(TMP_IDX);
                ld  = pick(SEL_W'(sa_q));
              end
            endcase
          end
        end
        default: begin
          sel = SEL_W'(EXT_IDX);
          ld  = pick(SEL_W'(da_q));
        end
      endcase
    end
  end

  assign busy = run_q;
  assign done = done_q;
endmodule

// File: rtl/regswap_bus_top.sv
module regswap_bus_top
  import swapbus_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [1:0]               cmd_dst_a,
  input  logic [1:0]               cmd_src_a,
  input  logic [1:0]               cmd_dst_b,
  input  logic [1:0]               cmd_src_b,
  input  logic [DATA_W-1:0]        ext_data,
  output logic                     busy,
  output logic                     done,
  output logic [2:0]               bus_sel,
  output logic [4:0]               bus_load,
  output logic [DATA_W-1:0]        bus_data,
  output logic [4*DATA_W-1:0]      gp_regs,
  output logic [DATA_W-1:0]        tmp_reg
);
  logic [1:0]                        rst_pipe;
  logic                              rst_int_n;
  logic [NUM_STORE-1:0][DATA_W-1:0]  store_q;
  logic [NUM_SRC-1:0][DATA_W-1:0]    src_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  swapbus_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_dst_a (cmd_dst_a),
    .cmd_src_a (cmd_src_a),
    .cmd_dst_b (cmd_dst_b),
    .cmd_src_b (cmd_src_b),
    .busy      (busy),
    .done      (done),
    .sel       (bus_sel),
    .ld        (bus_load)
  );

  assign src_all = {ext_data, store_q};

  swapbus_srcmux #(
    .DATA_W (DATA_W),
    .NUM_IN (NUM_SRC),
    .SEL_W  (SEL_W)
  ) u_mux (
    .src (src_all),
    .sel (bus_sel),
    .bus (bus_data)
  );

  swapbus_store #(
    .DATA_W  (DATA_W),
    .NUM_REG (NUM_STORE)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld       (bus_load),
    .bus_data (bus_data),
    .q        (store_q)
  );

  for (genvar g = 0; g < NUM_GP; g++) begin : g_out
    assign gp_regs[g*DATA_W +: DATA_W] = store_q[g];
  end
  assign tmp_reg = store_q[TMP_IDX];
endmodule

// File: rtl/swapbus_chk.sv
module swapbus_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                busy,
  input logic                done,
  input logic [2:0]          bus_sel,
  input logic [4:0]          bus_load,
  input logic [DATA_W-1:0]   bus_data,
  input logic [4*DATA_W-1:0] gp_regs,
  input logic [DATA_W-1:0]   tmp_reg
);
  logic [4:0][DATA_W-1:0] view;
  assign view = {tmp_reg, gp_regs};

  for (genvar g = 0; g < 5; g++) begin : g_reg
    AST_LOAD_TAKES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_load[g]) |-> view[g] == $past(bus_data)); // R1
    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_load[g]) |-> view[g] == $past(view[g])); // R1
  end

  AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bus_sel <= 3'd5); // R2
  AST_SCRATCH_FROM_GP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_load[4] |-> bus_sel < 3'd4); // R5
  AST_EXT_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel == 3'd5 |-> $countones(bus_load) == 1); // R7
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_load == 5'd0); // R8
  AST_TAKE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && $past(rst_n)) |=> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
endmodule

bind regswap_bus_top swapbus_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .busy      (busy),
  .done      (done),
  .bus_sel   (bus_sel),
  .bus_load  (bus_load),
  .bus_data  (bus_data),
  .gp_regs   (gp_regs),
  .tmp_reg   (tmp_reg)
);

// File: tb/sim_regswap_bus_top.sv
module sim_regswap_bus_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op, cmd_dst_a, cmd_src_a, cmd_dst_b, cmd_src_b;
  logic [W-1:0] ext_data;
  logic         busy, done;
  logic [2:0]   bus_sel;
  logic [4:0]   bus_load;
  logic [W-1:0] bus_data;
  logic [4*W-1:0] gp_regs;
  logic [W-1:0] tmp_reg;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [W-1:0] exp_r [0:4];
  logic [2:0]   sel_log [0:3];
  logic [4:0]   ld_log  [0:3];

  always #4 clk = ~clk;

  regswap_bus_top #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dst_a(cmd_dst_a), .cmd_src_a(cmd_src_a), .cmd_dst_b(cmd_dst_b),
    .cmd_src_b(cmd_src_b), .ext_data(ext_data), .busy(busy), .done(done),
    .bus_sel(bus_sel), .bus_load(bus_load), .bus_data(bus_data),
    .gp_regs(gp_regs), .tmp_reg(tmp_reg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < 4; k++)
      check(gp_regs[k*W +: W] == exp_r[k], req, gp_regs[k*W +: W], exp_r[k]);
    check(tmp_reg == exp_r[4], req, tmp_reg, exp_r[4]);
  endtask

  // Issues one command, checks the busy length and the done pulse.
  // poke: raise cmd_valid (load of 8'hEE into R0) during the second busy cycle.
  task automatic run_cmd(input logic [1:0] op, input logic [1:0] da, input logic [1:0] sa,
                         input logic [1:0] db, input logic [1:0] sb, input logic [W-1:0] ed,
                         input int exp_len, input string req, input bit poke);
    int cnt;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_dst_a = da; cmd_src_a = sa;
    cmd_dst_b = db; cmd_src_b = sb; ext_data = ed;
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 8) begin
      if (cnt < 4) begin sel_log[cnt] = bus_sel; ld_log[cnt] = bus_load; end
      cnt++;
      if (poke && cnt == 2) begin
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dst_a = 2'd0; ext_data = 8'hEE;
      end
      @(negedge clk);
      if (poke && cnt == 2) begin cmd_valid = 1'b0; ext_data = ed; end
    end
    check(cnt == exp_len, {req, " busy length"}, cnt, exp_len);
    check(done == 1'b1 && busy == 1'b0, {req, " done pulse"}, done, 1);
    @(negedge clk);
    check(done == 1'b0, {req, " done single"}, done, 0);
  endtask

  task automatic preload(input int seed);
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] v;
      v = W'(seed * 37 + k * 16 + 5);
      run_cmd(2'd3, 2'(k), 2'd0, 2'd0, 2'd0, v, 1, "R7", 0);
      exp_r[k] = v;
    end
    check_bank("R7 load");
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_dst_a = '0; cmd_src_a = '0;
    cmd_dst_b = '0; cmd_src_b = '0; ext_data = '0;
    for (int k = 0; k < 5; k++) exp_r[k] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy == 0 && done == 0 && bus_load == 0, "R9 idle", {busy, done, bus_load}, 0);
    check_bank("R9 cleared");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: every copy combination, R1 via bank contents
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) begin
        preload(d * 4 + s);
        run_cmd(2'd0, 2'(d), 2'(s), 2'd0, 2'd0, '0, 1, "R3", 0);
        check(sel_log[0] == 3'(s) && ld_log[0] == 5'(1 << d), "R3 bus controls",
              {sel_log[0], ld_log[0]}, {3'(s), 5'(1 << d)});
        exp_r[d] = exp_r[s];
        check_bank("R3 copy");
      end

    // R5 / R6: every exchange combination
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [W-1:0] t;
        preload(20 + i * 4 + j);
        if (i == j) begin
          run_cmd(2'd2, 2'(i), 2'(j), 2'd0, 2'd0, '0, 1, "R6", 0);
          check(ld_log[0] == 5'd0, "R6 no load", ld_log[0], 0);
          check_bank("R6 unchanged");
        end else begin
          run_cmd(2'd2, 2'(i), 2'(j), 2'd0, 2'd0, '0, 3, "R5", 0);
          check(sel_log[0] == 3'(i) && ld_log[0] == 5'b10000, "R5 step1",
                {sel_log[0], ld_log[0]}, {3'(i), 5'b10000});
          check(sel_log[1] == 3'(j) && ld_log[1] == 5'(1 << i), "R5 step2",
                {sel_log[1], ld_log[1]}, {3'(j), 5'(1 << i)});
          check(sel_log[2] == 3'd4 && ld_log[2] == 5'(1 << j), "R5 step3",
                {sel_log[2], ld_log[2]}, {3'd4, 5'(1 << j)});
          t = exp_r[i]; exp_r[4] = t; exp_r[i] = exp_r[j]; exp_r[j] = t;
          check_bank("R5 exchange");
        end
      end

    // R4: pairs, second copy reads result of the first
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 4; s++) begin
        logic [1:0] db, sb;
        db = 2'(s + 1); sb = 2'(d);
        preload(40 + d * 4 + s);
        run_cmd(2'd1, 2'(d), 2'(s), db, sb, '0, 2, "R4", 0);
        check(sel_log[0] == 3'(s) && sel_log[1] == 3'(sb), "R4 select order",
              {sel_log[0], sel_log[1]}, {3'(s), 3'(sb)});
        exp_r[d] = exp_r[s];
        exp_r[db] = exp_r[sb];
        check_bank("R4 pair");
      end

    // R8: request during busy is ignored; R2 bus_data on external source
    preload(77);
    run_cmd(2'd2, 2'd0, 2'd3, 2'd0, 2'd0, '0, 3, "R8", 1);
    begin
      logic [W-1:0] t;
      t = exp_r[0]; exp_r[4] = t; exp_r[0] = exp_r[3]; exp_r[3] = t;
    end
    check_bank("R8 ignored request");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_dst_a = 2'd2; ext_data = 8'h5A;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(bus_sel == 3'd5 && bus_data == 8'h5A, "R2 ext source", bus_data, 8'h5A);
    @(negedge clk);
    exp_r[2] = 8'h5A;
    check_bank("R7 ext load");

    // R9: reset in the middle of an exchange
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_dst_a = 2'd1; cmd_src_a = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 5; k++) exp_r[k] = '0;
    check(busy == 0 && bus_load == 0, "R9 mid reset idle", {busy, bus_load}, 0);
    check_bank("R9 mid reset");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule